// File: doc/BRIEF.md
# Single-Precision Result Packer with Rounding

This block turns an unpacked floating-point value, as produced inside an arithmetic datapath, into a 32-bit IEEE-754 single-precision word. The value arrives as a class code, a sign, a signed unbiased exponent and a wide mantissa whose top bit is the leading one; the bits below the 24 kept ones, together with a separate sticky input, decide the rounding. A 2-bit mode selects one of four directed rounding behaviours.

The packing logic is purely combinational. The packed word and four status flags (inexact, underflow, overflow, operand error) are captured in an output register, so every result appears on the clock edge after its operands are presented. Small values go down a denormalising path that may round back up into the smallest normal value. Large values saturate either to infinity or to the largest finite magnitude, depending on mode and sign. NaN payload bits are carried through.

Top module: `fp32pk_packer`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the word and all four flags become zero. Otherwise each output is the packed result of the inputs sampled at that edge.
- R2: Class code 3 (NaN) yields sign, exponent field 0xFF and fraction equal to the 23 mantissa bits directly below the leading bit `mant_i[MANT_W-1]`, with all flags clear.
- R3: Class code 2 (infinity) yields sign, exponent 0xFF and a zero fraction, with all flags clear, whatever the exponent and mantissa inputs hold.
- R4: Class code 0 (zero) yields only the sign bit, with all flags clear, in every rounding mode and with sticky set.
- R5: For class code 1 (number), the exponent field is the unbiased exponent plus 127 and the fraction is `mant_i[MANT_W-2 -: 23]` rounded. Inexact is set exactly when any dropped mantissa bit or `sticky_i` is set.
- R6: Rounding mode codes are 0 nearest with ties to even, 1 toward zero, 2 toward minus infinity, and 3 toward plus infinity. A directed mode increments the magnitude only for an inexact value of the matching sign.
- R7: When rounding a normal value carries the significand to 2.0, the exponent field rises by one and the fraction becomes zero.
- R8: A biased exponent of 0 or less sets underflow. The mantissa, including its leading one, is then shifted right by (1 - biased exponent) places before rounding, and the exponent field is 0. Shifts past the mantissa width fold every bit into sticky.
- R9: A denormalised value that rounds up to 2^-126 is returned as the smallest normal, 0x00800000 with the sign applied.
- R10: A biased exponent of 255 or more after rounding sets overflow, operand error and inexact. A result with exponent 254 and an all-ones fraction is not an overflow.
- R11: On overflow the output is infinity (exponent 0xFF, zero fraction) in mode 0. It is also infinity in mode 3 for a positive value and in mode 2 for a negative value. In every other case it is the largest finite magnitude, exponent 254 with all-ones fraction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cls_i | input | 2 | Class: 0 zero, 1 number, 2 infinity, 3 NaN |
| sign_i | input | 1 | Sign of the value (1 = negative) |
| exp_i | input | EXP_W | Signed unbiased exponent |
| mant_i | input | MANT_W | Mantissa, leading one at the top bit, guard/round/extra bits at the bottom |
| sticky_i | input | 1 | OR of any bits already discarded below `mant_i` |
| rmode_i | input | 2 | Rounding mode code |
| word_o | output | 32 | Packed single-precision word |
| inexact_o | output | 1 | Result differs from the exact value |
| underflow_o | output | 1 | Denormalising path was taken |
| overflow_o | output | 1 | Exponent out of range after rounding |
| operr_o | output | 1 | Operand error raised with overflow |

## Verification
Every result and every flag is due exactly one rising edge after its operands are applied. No path is longer or shorter than that. The bench drives operands on a falling edge, lets one rising edge pass, and compares word and flags together on the next falling edge, so each check sees the register loaded from its own stimulus. Reset is checked the same way, with non-zero operands held on the inputs during the reset edge. The bound checker compares outputs against inputs taken with `$past` one cycle back, gated on reset having been released in that cycle.

// File: rtl/fp32pk_pkg.sv
// Package: shared encodings and field constants for the single-precision packer.
// Assumes the packed format is IEEE-754 binary32 (1/8/23).
package fp32pk_pkg;

    localparam int FRAC_W  = 23;
    localparam int EFLD_W  = 8;
    localparam int KEEP_W  = FRAC_W + 1;
    localparam int BIAS    = 127;
    localparam int EXP_TOP = 255;

    typedef enum logic [1:0] {
        CLS_ZERO = 2'd0,
        CLS_NUM  = 2'd1,
        CLS_INF  = 2'd2,
        CLS_NAN  = 2'd3
    } fp_class_e;

    typedef enum logic [1:0] {
        RM_NEAREST = 2'd0,
        RM_ZERO    = 2'd1,
        RM_DOWN    = 2'd2,
        RM_UP      = 2'd3
    } rmode_e;

    typedef struct packed {
        logic operr;
        logic overflow;
        logic underflow;
        logic inexact;
    } flags_t;

    localparam logic [31:0] WORD_INF     = 32'h7F80_0000;
    localparam logic [31:0] WORD_MAX_FIN = 32'h7F7F_FFFF;

endpackage

// File: rtl/fp32pk_rshift.sv
// Module: right shifter that folds every bit shifted out into a sticky bit.
// Assumes amt is already clamped by the caller; stages that shift by the
// full width or more simply empty the word into sticky.
module fp32pk_rshift #(
    parameter int W    = 32,
    parameter int SH_W = 6
) (
    input  logic [W-1:0]    din,
    input  logic [SH_W-1:0] amt,
    input  logic            sticky_in,
    output logic [W-1:0]    dout,
    output logic            sticky_out
);

    logic [W-1:0] work;
    logic         lost;

    // Logarithmic shift, one stage per amount bit, collecting lost bits.
    always_comb begin
        work = din;
        lost = sticky_in;
        for (int k = 0; k < SH_W; k++) begin
            if (amt[k]) begin
                if ((1 << k) >= W) begin
                    lost = lost | (|work);
                    work = '0;
                end else begin
                    lost = lost | (|(work & ~({W{1'b1}} << (1 << k))));
                    work = work >> (1 << k);
                end
            end
        end
        dout       = work;
        sticky_out = lost;
    end

endmodule

// File: rtl/fp32pk_rounder.sv
// Module: round-increment decision and add for a kept significand.
// Assumes guard, round and sticky describe the bits below kept's LSB.
// The sum is one bit wider so a carry into 2.0 is visible to the caller.
module fp32pk_rounder
    import fp32pk_pkg::*;
#(
    parameter int KW = KEEP_W
) (
    input  logic [KW-1:0] kept,
    input  logic          guard,
    input  logic          rnd,
    input  logic          stk,
    input  logic          sign,
    input  rmode_e        mode,
    output logic [KW:0]   sum,
    output logic          inexact
);

    logic bump;

    // Decide whether the magnitude is incremented under the selected mode.
    always_comb begin
        inexact = guard | rnd | stk;
        unique case (mode)
            RM_NEAREST: bump = guard & (rnd | stk | kept[0]);
            RM_ZERO:    bump = 1'b0;
            RM_DOWN:    bump = inexact & sign;
            RM_UP:      bump = inexact & ~sign;
            default:    bump = 1'b0;
        endcase
    end

    // Apply the increment with the carry kept.
    always_comb begin
        sum = {1'b0, kept} + {{KW{1'b0}}, bump};
    end

endmodule

// File: rtl/fp32pk_ovf_sel.sv
// Module: chooses the saturated result for an overflowing value.
// Assumes it is only consulted when the caller has detected overflow.
module fp32pk_ovf_sel
    import fp32pk_pkg::*;
(
    input  logic        sign,
    input  rmode_e      mode,
    output logic [31:0] word
);

    logic to_inf;

    // Infinity when the mode rounds away from zero for this sign.
    always_comb begin
        unique case (mode)
            RM_NEAREST: to_inf = 1'b1;
            RM_ZERO:    to_inf = 1'b0;
            RM_DOWN:    to_inf = sign;
            RM_UP:      to_inf = ~sign;
            default:    to_inf = 1'b1;
        endcase
        word = (to_inf ? WORD_INF : WORD_MAX_FIN) | {sign, 31'd0};
    end

endmodule

// File: rtl/fp32pk_packer.sv
// Module: top of the single-precision packer. Combinational packing of an
// unpacked value with a registered word/flag output (one cycle latency).
// Assumes mant_i[MANT_W-1] is the leading one for class NUM, that at least
// three bits lie below the 24 kept bits, and that NaN mantissas already
// carry the quiet bit.
module fp32pk_packer
    import fp32pk_pkg::*;
#(
    parameter int MANT_W = 32,
    parameter int EXP_W  = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [1:0]              cls_i,
    input  logic                    sign_i,
    input  logic signed [EXP_W-1:0] exp_i,
    input  logic [MANT_W-1:0]       mant_i,
    input  logic                    sticky_i,
    input  logic [1:0]              rmode_i,
    output logic [31:0]             word_o,
    output logic                    inexact_o,
    output logic                    underflow_o,
    output logic                    overflow_o,
    output logic                    operr_o
);

    localparam int LOW_W  = MANT_W - KEEP_W;
    localparam int EB_W   = EXP_W + 2;
    localparam int SH_W   = $clog2(MANT_W) + 1;
    localparam int SH_MAX = (1 << SH_W) - 1;

    fp_class_e              cls;
    rmode_e                 mode;
    logic signed [EB_W-1:0] exp_b;
    logic signed [EB_W-1:0] sh_need;
    logic signed [EB_W-1:0] exp_r;
    logic                   sub_path;
    logic [SH_W-1:0]        sh_amt;
    logic [MANT_W-1:0]      m_sh;
    logic                   st_sh;
    logic [KEEP_W-1:0]      kept;
    logic                   guard, rnd, stk;
    logic [KEEP_W:0]        sum;
    logic                   inexact_r;
    logic                   ovf;
    logic [31:0]            sat_word;
    logic [FRAC_W-1:0]      frac_n;
    logic [31:0]            word_d;
    flags_t                 flags_d;
    flags_t                 flags_q;
    logic [31:0]            word_q;

    // Decode the input codes and bias the exponent.
    always_comb begin
        cls      = fp_class_e'(cls_i);
        mode     = rmode_e'(rmode_i);
        exp_b    = EB_W'(exp_i) + EB_W'(BIAS);
        sub_path = (exp_b <= 0);
        sh_need  = EB_W'(1) - exp_b;
    end

    // Clamp the denormalising shift; anything past the width is all sticky.
    always_comb begin
        if (!sub_path)
            sh_amt = '0;
        else if (sh_need > EB_W'(SH_MAX))
            sh_amt = SH_W'(SH_MAX);
        else
            sh_amt = sh_need[SH_W-1:0];
    end

    fp32pk_rshift #(
        .W    (MANT_W),
        .SH_W (SH_W)
    ) u_shift (
        .din        (mant_i),
        .amt        (sh_amt),
        .sticky_in  (sticky_i),
        .dout       (m_sh),
        .sticky_out (st_sh)
    );

    // Split the shifted mantissa into kept bits and guard/round/sticky.
    always_comb begin
        kept  = m_sh[MANT_W-1 -: KEEP_W];
        guard = m_sh[LOW_W-1];
        rnd   = m_sh[LOW_W-2];
        stk   = st_sh;
        if (LOW_W > 2)
            stk = st_sh | (|(m_sh & ~({MANT_W{1'b1}} << (LOW_W - 2))));
    end

    fp32pk_rounder #(
        .KW (KEEP_W)
    ) u_round (
        .kept    (kept),
        .guard   (guard),
        .rnd     (rnd),
        .stk     (stk),
        .sign    (sign_i),
        .mode    (mode),
        .sum     (sum),
        .inexact (inexact_r)
    );

    fp32pk_ovf_sel u_sat (
        .sign (sign_i),
        .mode (mode),
        .word (sat_word)
    );

    // Post-rounding exponent adjust and overflow detection for normals.
    always_comb begin
        exp_r  = exp_b + (sum[KEEP_W] ? EB_W'(1) : EB_W'(0));
        frac_n = sum[KEEP_W] ? '0 : sum[FRAC_W-1:0];
        ovf    = !sub_path && (exp_r >= EB_W'(EXP_TOP));
    end

    // Assemble the next word and flags for each class and path.
    always_comb begin
        word_d  = '0;
        flags_d = '0;
        unique case (cls)
            CLS_ZERO: begin
                word_d = {sign_i, 31'd0};
            end
            CLS_INF: begin
                word_d = {sign_i, 31'd0} | WORD_INF;
            end
            CLS_NAN: begin
                word_d = {sign_i, {EFLD_W{1'b1}}, mant_i[MANT_W-2 -: FRAC_W]};
            end
            CLS_NUM: begin
                if (sub_path) begin
                    word_d            = {sign_i, 7'd0, sum[KEEP_W-1:0]};
                    flags_d.underflow = 1'b1;
                    flags_d.inexact   = inexact_r;
                end else if (ovf) begin
                    word_d           = sat_word;
                    flags_d.overflow = 1'b1;
                    flags_d.operr    = 1'b1;
                    flags_d.inexact  = 1'b1;
                end else begin
                    word_d          = {sign_i, exp_r[EFLD_W-1:0], frac_n};
                    flags_d.inexact = inexact_r;
                end
            end
            default: word_d = '0;
        endcase
    end

    // Output register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q  <= '0;
            flags_q <= '0;
        end else begin
            word_q  <= word_d;
            flags_q <= flags_d;
        end
    end

    assign word_o      = word_q;
    assign inexact_o   = flags_q.inexact;
    assign underflow_o = flags_q.underflow;
    assign overflow_o  = flags_q.overflow;
    assign operr_o     = flags_q.operr;

endmodule

// File: rtl/fp32pk_packer_chk.sv
// Module: property checker bound to the packer; relates each registered
// output to the inputs one cycle earlier. Assumes the one-cycle latency.
module fp32pk_packer_chk #(
    parameter int MANT_W = 32,
    parameter int EXP_W  = 12
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [1:0]              cls_i,
    input logic                    sign_i,
    input logic signed [EXP_W-1:0] exp_i,
    input logic [MANT_W-1:0]       mant_i,
    input logic                    sticky_i,
    input logic [1:0]              rmode_i,
    input logic [31:0]             word_o,
    input logic                    inexact_o,
    input logic                    underflow_o,
    input logic                    overflow_o,
    input logic                    operr_o
);

    logic [3:0] flags;
    assign flags = {operr_o, overflow_o, underflow_o, inexact_o};

    assert_nan_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cls_i) == 2'd3) |->
        (word_o[30:23] == 8'hFF && word_o[22:0] == $past(mant_i[MANT_W-2 -: 23]) && flags == 4'd0));

    assert_inf_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cls_i) == 2'd2) |->
        (word_o == {$past(sign_i), 31'h7F80_0000} && flags == 4'd0));

    assert_zero_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cls_i) == 2'd0) |->
        (word_o == {$past(sign_i), 31'd0} && flags == 4'd0));

    assert_sign_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (word_o[31] == $past(sign_i)));

    assert_unfl_small_exp_R8: assert property (@(posedge clk) disable iff (!rst_n)
        underflow_o |-> (word_o[30:24] == 7'd0 && !overflow_o));

    assert_ovf_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_o |-> (operr_o && inexact_o));

    assert_ovf_word_R11: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_o |-> (word_o[30:0] == 31'h7F80_0000 || word_o[30:0] == 31'h7F7F_FFFF));

endmodule

bind fp32pk_packer fp32pk_packer_chk #(
    .MANT_W (MANT_W),
    .EXP_W  (EXP_W)
) u_chk (.*);

// File: tb/fp32pk_packer_tb_top.sv
// Directed bench: one task per scenario, each comparing word and flags.
module fp32pk_packer_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int MANT_W     = 32;
    localparam int EXP_W      = 12;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic [1:0]              cls_i = 2'd0;
    logic                    sign_i = 1'b0;
    logic signed [EXP_W-1:0] exp_i = '0;
    logic [MANT_W-1:0]       mant_i = '0;
    logic                    sticky_i = 1'b0;
    logic [1:0]              rmode_i = 2'd0;
    logic [31:0]             word_o;
    logic                    inexact_o, underflow_o, overflow_o, operr_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fp32pk_packer #(.MANT_W(MANT_W), .EXP_W(EXP_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .cls_i(cls_i), .sign_i(sign_i), .exp_i(exp_i),
        .mant_i(mant_i), .sticky_i(sticky_i), .rmode_i(rmode_i), .word_o(word_o),
        .inexact_o(inexact_o), .underflow_o(underflow_o), .overflow_o(overflow_o),
        .operr_o(operr_o)
    );

    // Flag vector order: {operr, overflow, underflow, inexact}
    task automatic check(input string req, input logic [31:0] exp_w, input logic [3:0] exp_f);
        logic [3:0] got_f;
        got_f = {operr_o, overflow_o, underflow_o, inexact_o};
        n_checks++;
        if (word_o !== exp_w || got_f !== exp_f) begin
            n_fails++;
            $display("FAIL %s: word=%08h flags=%04b expected word=%08h flags=%04b",
                     req, word_o, got_f, exp_w, exp_f);
        end
    endtask

    // Drive on a falling edge, let one rising edge load, check at next fall.
    task automatic apply(input int cls, input bit sg, input int ex,
                         input logic [31:0] mt, input bit st, input int md,
                         input string req, input logic [31:0] exp_w, input logic [3:0] exp_f);
        @(negedge clk);
        cls_i = 2'(cls); sign_i = sg; exp_i = EXP_W'(ex);
        mant_i = mt; sticky_i = st; rmode_i = 2'(md);
        @(posedge clk);
        @(negedge clk);
        check(req, exp_w, exp_f);
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0; cls_i = 2'd2; sign_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R1 reset clears", 32'h0, 4'b0000);
        rst_n = 1'b1;
    endtask

    task automatic t_nan();
        apply(3, 0, 5, 32'hC000_1234, 0, 0, "R2 nan payload", 32'h7FC0_0012, 4'b0000);
        apply(3, 1, -200, 32'hE000_0000, 1, 3, "R2 nan negative", 32'hFFE0_0000, 4'b0000);
    endtask

    task automatic t_inf();
        apply(2, 1, 77, 32'hFFFF_FFFF, 1, 0, "R3 inf ignores fields", 32'hFF80_0000, 4'b0000);
    endtask

    task automatic t_zero();
        apply(0, 1, 30, 32'h8000_00FF, 1, 3, "R4 negative zero", 32'h8000_0000, 4'b0000);
    endtask

    task automatic t_normal();
        apply(1, 0, 0, 32'h8000_0000, 0, 0, "R5 one", 32'h3F80_0000, 4'b0000);
        apply(1, 1, 0, 32'hC000_0000, 0, 0, "R5 minus 1.5", 32'hBFC0_0000, 4'b0000);
        apply(1, 0, -126, 32'h8000_0000, 0, 0, "R5 smallest normal", 32'h0080_0000, 4'b0000);
    endtask

    task automatic t_modes();
        apply(1, 0, 0, 32'h8000_0080, 0, 0, "R6 tie even stays", 32'h3F80_0000, 4'b0001);
        apply(1, 0, 0, 32'h8000_0180, 0, 0, "R6 tie odd rounds up", 32'h3F80_0002, 4'b0001);
        apply(1, 0, 0, 32'h8000_00C0, 0, 0, "R6 above half", 32'h3F80_0001, 4'b0001);
        apply(1, 0, 0, 32'h8000_00FF, 0, 1, "R6 toward zero", 32'h3F80_0000, 4'b0001);
        apply(1, 1, 0, 32'h8000_0001, 0, 2, "R6 down negative", 32'hBF80_0001, 4'b0001);
        apply(1, 0, 0, 32'h8000_0001, 0, 2, "R6 down positive", 32'h3F80_0000, 4'b0001);
        apply(1, 0, 0, 32'h8000_0000, 1, 3, "R6 up sticky only", 32'h3F80_0001, 4'b0001);
        apply(1, 1, 0, 32'h8000_0001, 0, 3, "R6 up negative", 32'hBF80_0000, 4'b0001);
    endtask

    task automatic t_carry();
        apply(1, 0, 0, 32'hFFFF_FF80, 0, 0, "R7 carry to 2.0", 32'h4000_0000, 4'b0001);
    endtask

    task automatic t_subnormal();
        apply(1, 0, -127, 32'h8000_0000, 0, 0, "R8 half of min normal", 32'h0040_0000, 4'b0010);
        apply(1, 0, -149, 32'h8000_0000, 0, 0, "R8 min subnormal", 32'h0000_0001, 4'b0010);
        apply(1, 1, -150, 32'h8000_0000, 0, 0, "R8 tie to zero", 32'h8000_0000, 4'b0011);
        apply(1, 0, -160, 32'h8000_0000, 0, 3, "R8 all sticky up", 32'h0000_0001, 4'b0011);
    endtask

    task automatic t_sub_to_normal();
        apply(1, 1, -127, 32'hFFFF_FF00, 0, 0, "R9 round into normal", 32'h8080_0000, 4'b0011);
    endtask

    task automatic t_overflow_detect();
        apply(1, 0, 127, 32'hFFFF_FF00, 0, 0, "R10 max finite exact", 32'h7F7F_FFFF, 4'b0000);
        apply(1, 0, 127, 32'hFFFF_FF80, 0, 0, "R10 carry overflow", 32'h7F80_0000, 4'b1101);
        apply(1, 1, 600, 32'h8000_0000, 0, 0, "R10 large exponent", 32'hFF80_0000, 4'b1101);
    endtask

    task automatic t_overflow_select();
        apply(1, 0, 128, 32'h8000_0000, 0, 1, "R11 zero mode pos", 32'h7F7F_FFFF, 4'b1101);
        apply(1, 1, 128, 32'h8000_0000, 0, 1, "R11 zero mode neg", 32'hFF7F_FFFF, 4'b1101);
        apply(1, 0, 128, 32'h8000_0000, 0, 3, "R11 up pos", 32'h7F80_0000, 4'b1101);
        apply(1, 1, 128, 32'h8000_0000, 0, 3, "R11 up neg", 32'hFF7F_FFFF, 4'b1101);
        apply(1, 1, 128, 32'h8000_0000, 0, 2, "R11 down neg", 32'hFF80_0000, 4'b1101);
        apply(1, 0, 128, 32'h8000_0000, 0, 2, "R11 down pos", 32'h7F7F_FFFF, 4'b1101);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        t_nan();
        t_inf();
        t_zero();
        t_normal();
        t_modes();
        t_carry();
        t_subnormal();
        t_sub_to_normal();
        t_overflow_detect();
        t_overflow_select();
        t_reset();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule